// File: doc/BRIEF.md
# Recursive Vertical Luma Noise Filter

The block removes noise from an 8-bit unsigned luminance stream, one pixel at a time, using only line storage. Each result is formed from a reference pixel of the line just received, two more pixels of that same unfiltered line two positions to each side, and five pixels of the previously filtered line. Those five sit at offsets -9, -4, 0, +4 and +9 around the reference position, plus a small weave shift. A tap joins the average only when it lies close enough in value to the reference. The result is stored back as the new filtered line, so the filter is recursive in the vertical direction.

Lines are framed by a one-cycle `line_start` pulse, and pixels are marked with `pix_valid`. The filtered version of line k leaves the block while line k+1 enters, so the output is one line late. The noise threshold and a strength code come in as plain inputs. Strength zero turns the filter into a one-line delay. The weave phase steps through a four-line cycle, and the field parity decides the direction of the shift.

A control state machine orders the work. Reset puts it in S_IDLE. The transition "first frame" (S_IDLE to S_FILL on `line_start`) begins capture of the first line, which produces no output. The transition "begin streaming" (S_FILL to S_STREAM on the next `line_start`) enables emission. In S_STREAM every further `line_start` takes the "line turn" self-loop.

Top module: `luma_vrnr`

## Requirements
- R1: A synchronous active-low reset clears `out_valid` and `pix_out`, sets every stored filtered pixel to 0 and sets the weave phase to 0, so the first filtered line is computed against a line of zeros.
- R2: The first line after reset produces no output. After that, the filtered pixel i of line k is presented with `out_valid` high in the cycle after pixel i of line k+1 is accepted. Only pixel indices below the length of line k are emitted.
- R3: For reference index i with weave shift s, the taps are the unfiltered pixels i-2, i and i+2 of the delayed line and the filtered pixels i+s-9, i+s-4, i+s, i+s+4 and i+s+9 of the previous filtered line.
- R4: The effective threshold is `noise_thr` multiplied by the saturated strength. A tap is included when its absolute difference from the reference is strictly less than the effective threshold. The reference is always included, so an effective threshold of 0 returns the reference.
- R5: The result is floor((sum + count/2) / count) over the included pixels, where count runs from 1 to 8.
- R6: Lines get weave phases 0, 1, 2, 3, 0, ... starting at 0 with the first line after reset. Phases 0, 1, 2 and 3 give shifts 0, +1, 0 and -1 when `field_odd` was 0 at the line's `line_start`, and the negated shifts when it was 1.
- R7: A tap position below 0 uses pixel 0, and a position at or past the line length L uses pixel L-1.
- R8: Each emitted result is written back as the filtered pixel at its index and serves as a filtered tap for the next line.
- R9: When `strength` is 0 the output equals the unfiltered reference pixel, and that value is written back.
- R10: `strength` values above 10 behave as 10.
- R11: A pixel that arrives in the same cycle as `line_start`, or after 1024 pixels of a line, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Marks a valid input pixel |
| line_start | input | 1 | One-cycle pulse ahead of each line |
| field_odd | input | 1 | Field parity, sampled at `line_start` |
| pix_in | input | 8 | Unfiltered luminance pixel |
| noise_thr | input | 8 | Noise threshold |
| strength | input | 4 | Filter strength, 0 = bypass, 1..10 |
| out_valid | output | 1 | Marks a filtered output pixel |
| pix_out | output | 8 | Filtered luminance pixel, one line late |

## Verification
The properties assume the inputs are well formed. `line_start` is a single-cycle pulse with `pix_valid` low in that cycle. `noise_thr` and `strength` stay constant across a line, and successive lines have the same length, so every stored filtered pixel in a window comes from the line just emitted. The bounds property also assumes the output of a non-bypassed pixel cannot leave the range of its eight taps. The bench respects all of these: it drives lines of one fixed length with idle gaps between them, and it changes the threshold, strength and parity only in the `line_start` cycle.

// File: rtl/nr_pkg.sv
package nr_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FILL   = 2'd1,
        S_STREAM = 2'd2
    } nr_state_e;

    localparam int N_FTAP       = 5;
    localparam int N_CSIDE      = 2;
    localparam int N_SIDE       = N_FTAP + N_CSIDE;
    localparam int MAX_STRENGTH = 10;

    // offset of filtered tap j from the (shifted) reference position
    function automatic int ftap_off(input int j);
        case (j)
            0:       return -9;
            1:       return -4;
            2:       return 0;
            3:       return 4;
            default: return 9;
        endcase
    endfunction

    // offset of unfiltered side tap j from the reference position
    function automatic int ctap_off(input int j);
        return (j == 0) ? -2 : 2;
    endfunction

    // weave shift for a line given its phase and field parity
    function automatic logic signed [2:0] weave_shift(input logic [1:0] ph,
                                                      input logic odd);
        logic signed [2:0] base;
        case (ph)
            2'd1:    base = 3'sd1;
            2'd3:    base = -3'sd1;
            default: base = 3'sd0;
        endcase
        return odd ? -base : base;
    endfunction

endpackage

// File: rtl/nr_addr_gen.sv
module nr_addr_gen
    import nr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [AW:0]                   idx,
    input  logic [AW:0]                   len,
    input  logic signed [2:0]             shift,
    output logic [N_FTAP-1:0][AW-1:0]     f_addr,
    output logic [N_CSIDE-1:0][AW-1:0]    c_addr,
    output logic [AW-1:0]                 ref_addr
);
    localparam int PW = AW + 3;
    typedef logic signed [PW-1:0] pos_t;

    pos_t idx_s;
    pos_t sh_s;
    pos_t hi_s;

    assign idx_s    = pos_t'({2'b00, idx});
    assign sh_s     = pos_t'(shift);
    assign hi_s     = pos_t'({2'b00, len}) - pos_t'(1);
    assign ref_addr = idx[AW-1:0];

    function automatic logic [AW-1:0] clampf(input pos_t p, input pos_t hi);
        if (p < pos_t'(0)) begin
            return '0;
        end else if (p > hi) begin
            return hi[AW-1:0];
        end else begin
            return p[AW-1:0];
        end
    endfunction

    for (genvar j = 0; j < N_FTAP; j++) begin : g_ftap
        pos_t p;
        assign p         = idx_s + sh_s + pos_t'(ftap_off(j));
        assign f_addr[j] = clampf(p, hi_s);
    end

    for (genvar j = 0; j < N_CSIDE; j++) begin : g_ctap
        pos_t p;
        assign p         = idx_s + pos_t'(ctap_off(j));
        assign c_addr[j] = clampf(p, hi_s);
    end

endmodule

// File: rtl/nr_line_store.sv
module nr_line_store
    import nr_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    // unfiltered line banks
    input  logic                          c_we,
    input  logic                          c_wbank,
    input  logic [AW-1:0]                 c_waddr,
    input  logic [W-1:0]                  c_wdata,
    input  logic                          c_rbank,
    input  logic [2:0][AW-1:0]            c_raddr,
    output logic [2:0][W-1:0]             c_q,
    // filtered line banks
    input  logic                          f_we,
    input  logic                          f_wbank,
    input  logic [AW-1:0]                 f_waddr,
    input  logic [W-1:0]                  f_wdata,
    input  logic                          f_rbank,
    input  logic [N_FTAP-1:0][AW-1:0]     f_raddr,
    output logic [N_FTAP-1:0][W-1:0]      f_q
);
    logic [W-1:0] cmem [2][DEPTH];
    logic [W-1:0] fmem [2][DEPTH];

    always_ff @(posedge clk) begin
        if (c_we) begin
            cmem[c_wbank][c_waddr] <= c_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                for (int a = 0; a < DEPTH; a++) begin
                    fmem[b][a] <= '0;
                end
            end
        end else if (f_we) begin
            fmem[f_wbank][f_waddr] <= f_wdata;
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_crd
        assign c_q[k] = cmem[c_rbank][c_raddr[k]];
    end

    for (genvar k = 0; k < N_FTAP; k++) begin : g_frd
        assign f_q[k] = fmem[f_rbank][f_raddr[k]];
    end

endmodule

// File: rtl/nr_daf_core.sv
module nr_daf_core
    import nr_pkg::*;
#(
    parameter int W  = 8,
    parameter int TW = 12
) (
    input  logic [W-1:0]                  ref_px,
    input  logic [N_SIDE-1:0][W-1:0]      taps,
    input  logic [TW-1:0]                 thr_eff,
    input  logic                          bypass,
    output logic [W-1:0]                  result
);
    localparam int SW = W + 4;

    logic [N_SIDE-1:0]          inc;
    logic [N_SIDE-1:0][W-1:0]   contrib;
    logic [SW-1:0]              sum;
    logic [SW-1:0]              cnt;
    logic [SW-1:0]              quot;

    for (genvar t = 0; t < N_SIDE; t++) begin : g_tap
        logic [W-1:0] absd;
        assign absd       = (taps[t] > ref_px) ? (taps[t] - ref_px) : (ref_px - taps[t]);
        assign inc[t]     = (TW'(absd) < thr_eff);
        assign contrib[t] = inc[t] ? taps[t] : '0;
    end

    always_comb begin
        sum = SW'(ref_px);
        cnt = SW'(1);
        for (int t = 0; t < N_SIDE; t++) begin
            sum = sum + SW'(contrib[t]);
            cnt = cnt + SW'(inc[t]);
        end
        quot   = (sum + (cnt >> 1)) / cnt;
        result = bypass ? ref_px : quot[W-1:0];
    end

endmodule

// File: rtl/luma_vrnr.sv
module luma_vrnr
    import nr_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 1024,
    parameter int STR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              line_start,
    input  logic              field_odd,
    input  logic [W-1:0]      pix_in,
    input  logic [W-1:0]      noise_thr,
    input  logic [STR_W-1:0]  strength,
    output logic              out_valid,
    output logic [W-1:0]      pix_out
);
    localparam int AW = $clog2(DEPTH);
    localparam int TW = W + STR_W;
    localparam logic [AW:0]      DEPTH_V = (AW+1)'(DEPTH);
    localparam logic [STR_W-1:0] STR_MAX = STR_W'(MAX_STRENGTH);

    nr_state_e state_q, state_d;

    logic [AW:0]       wr_idx_q, prev_len_q;
    logic              raw_wb_q, f_rb_q;
    logic [1:0]        cur_phase_q, prev_phase_q;
    logic              cur_odd_q, prev_odd_q;
    logic              out_valid_q;
    logic [W-1:0]      pix_out_q;

    logic              accept;
    logic              emit;
    logic              turn;

    logic [N_FTAP-1:0][AW-1:0]   f_addr;
    logic [N_CSIDE-1:0][AW-1:0]  c_addr;
    logic [AW-1:0]               ref_addr;
    logic [2:0][AW-1:0]          c_raddr;
    logic [2:0][W-1:0]           c_q;
    logic [N_FTAP-1:0][W-1:0]    f_q;
    logic [N_SIDE-1:0][W-1:0]    side_taps;
    logic [W-1:0]                ref_px;
    logic [STR_W-1:0]            str_sat;
    logic [TW-1:0]               thr_eff;
    logic                        bypass;
    logic [W-1:0]                daf_res;
    logic signed [2:0]           shift;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state and decoded controls ----------------
    always_comb begin
        state_d = state_q;
        accept  = pix_valid && !line_start && (wr_idx_q < DEPTH_V);
        emit    = 1'b0;
        turn    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                accept = 1'b0;
                if (line_start) begin
                    state_d = S_FILL;
                end
            end
            S_FILL: begin
                if (line_start) begin
                    state_d = S_STREAM;
                    turn    = 1'b1;
                end
            end
            S_STREAM: begin
                emit = accept && (wr_idx_q < prev_len_q);
                turn = line_start;
            end
            default: begin
                state_d = S_IDLE;
                accept  = 1'b0;
            end
        endcase
    end

    // ---------------- line bookkeeping and output register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx_q     <= '0;
            prev_len_q   <= '0;
            raw_wb_q     <= 1'b0;
            f_rb_q       <= 1'b0;
            cur_phase_q  <= 2'd0;
            prev_phase_q <= 2'd0;
            cur_odd_q    <= 1'b0;
            prev_odd_q   <= 1'b0;
            out_valid_q  <= 1'b0;
            pix_out_q    <= '0;
        end else begin
            out_valid_q <= emit;
            if (emit) begin
                pix_out_q <= daf_res;
            end
            if (turn) begin
                prev_len_q   <= wr_idx_q;
                wr_idx_q     <= '0;
                raw_wb_q     <= ~raw_wb_q;
                prev_phase_q <= cur_phase_q;
                cur_phase_q  <= cur_phase_q + 2'd1;
                prev_odd_q   <= cur_odd_q;
                cur_odd_q    <= field_odd;
                if (state_q == S_STREAM) begin
                    f_rb_q <= ~f_rb_q;
                end
            end else if (line_start && state_q == S_IDLE) begin
                wr_idx_q    <= '0;
                cur_phase_q <= 2'd0;
                cur_odd_q   <= field_odd;
            end else if (accept) begin
                wr_idx_q <= wr_idx_q + 1'b1;
            end
        end
    end

    // ---------------- tap addressing ----------------
    assign shift = weave_shift(prev_phase_q, prev_odd_q);

    nr_addr_gen #(.AW(AW)) u_addr (
        .idx      (wr_idx_q),
        .len      (prev_len_q),
        .shift    (shift),
        .f_addr   (f_addr),
        .c_addr   (c_addr),
        .ref_addr (ref_addr)
    );

    assign c_raddr = {c_addr[1], ref_addr, c_addr[0]};

    nr_line_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .c_we    (accept),
        .c_wbank (raw_wb_q),
        .c_waddr (wr_idx_q[AW-1:0]),
        .c_wdata (pix_in),
        .c_rbank (~raw_wb_q),
        .c_raddr (c_raddr),
        .c_q     (c_q),
        .f_we    (emit),
        .f_wbank (~f_rb_q),
        .f_waddr (wr_idx_q[AW-1:0]),
        .f_wdata (daf_res),
        .f_rbank (f_rb_q),
        .f_raddr (f_addr),
        .f_q     (f_q)
    );

    // ---------------- weighting ----------------
    assign ref_px    = c_q[1];
    assign side_taps = {c_q[2], c_q[0], f_q};
    assign str_sat   = (strength > STR_MAX) ? STR_MAX : strength;
    assign thr_eff   = TW'(noise_thr) * TW'(str_sat);
    assign bypass    = (strength == '0);

    nr_daf_core #(.W(W), .TW(TW)) u_daf (
        .ref_px  (ref_px),
        .taps    (side_taps),
        .thr_eff (thr_eff),
        .bypass  (bypass),
        .result  (daf_res)
    );

    assign out_valid = out_valid_q;
    assign pix_out   = pix_out_q;

endmodule

// File: rtl/nr_vrnr_chk.sv
module nr_vrnr_chk
    import nr_pkg::*;
#(
    parameter int W     = 8,
    parameter int STR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pix_valid,
    input  logic                      line_start,
    input  logic [W-1:0]              noise_thr,
    input  logic [STR_W-1:0]          strength,
    input  logic                      out_valid,
    input  logic [W-1:0]              pix_out,
    input  nr_state_e                 st,
    input  logic [1:0]                phase,
    input  logic [W-1:0]              ref_px,
    input  logic [N_SIDE-1:0][W-1:0]  side_taps
);
    logic [1:0]   ls_cnt;
    logic [W-1:0] tmin, tmax;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_cnt <= 2'd0;
        end else if (line_start && ls_cnt != 2'd2) begin
            ls_cnt <= ls_cnt + 2'd1;
        end
    end

    always_comb begin
        tmin = ref_px;
        tmax = ref_px;
        for (int t = 0; t < N_SIDE; t++) begin
            if (side_taps[t] < tmin) tmin = side_taps[t];
            if (side_taps[t] > tmax) tmax = side_taps[t];
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !out_valid);

    p_first_line_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_cnt < 2'd2) |-> !out_valid);

    p_out_after_pixel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_valid));

    p_zero_thr_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(noise_thr) == '0) |-> (pix_out == $past(ref_px)));

    p_mean_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(strength) != '0) |->
            (pix_out >= $past(tmin) && pix_out <= $past(tmax)));

    p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(line_start) && $past(st) != S_IDLE) |-> (phase == $past(phase) + 2'd1));

    p_bypass_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(strength) == '0) |-> (pix_out == $past(ref_px)));

endmodule

bind luma_vrnr nr_vrnr_chk #(.W(W), .STR_W(STR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .line_start (line_start),
    .noise_thr  (noise_thr),
    .strength   (strength),
    .out_valid  (out_valid),
    .pix_out    (pix_out),
    .st         (state_q),
    .phase      (cur_phase_q),
    .ref_px     (ref_px),
    .side_taps  (side_taps)
);

// File: tb/luma_vrnr_tb_top.sv
module luma_vrnr_tb_top;

    localparam int L     = 24;
    localparam int NVEC  = 10;
    localparam int MAXGOT = 1024;

    // row: {thr[28:21], str[20:17], odd[16], base[15:8], amp[7:0]}
    localparam logic [28:0] VEC [NVEC] = '{
        {8'd10, 4'd3,  1'b0, 8'd120, 8'd15},
        {8'd10, 4'd3,  1'b0, 8'd120, 8'd15},
        {8'd6,  4'd2,  1'b0, 8'd60,  8'd40},
        {8'd0,  4'd5,  1'b0, 8'd200, 8'd30},
        {8'd12, 4'd0,  1'b1, 8'd90,  8'd60},
        {8'd3,  4'd15, 1'b1, 8'd90,  8'd20},
        {8'd20, 4'd10, 1'b1, 8'd10,  8'd100},
        {8'd8,  4'd4,  1'b0, 8'd140, 8'd50},
        {8'd5,  4'd7,  1'b1, 8'd30,  8'd25},
        {8'd9,  4'd1,  1'b0, 8'd180, 8'd70}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 1'b0;
    logic       line_start = 1'b0;
    logic       field_odd = 1'b0;
    logic [7:0] pix_in = '0;
    logic [7:0] noise_thr = '0;
    logic [3:0] strength = '0;
    logic       out_valid;
    logic [7:0] pix_out;

    int errors = 0;
    int checks = 0;
    int tot = 0;
    logic [7:0] got_all [MAXGOT];
    logic [7:0] cur     [L];
    logic [7:0] c_prev  [L];
    logic [7:0] fm      [L];
    logic [7:0] exp_ln  [L];

    always #10 clk = ~clk;

    luma_vrnr dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .line_start (line_start),
        .field_odd  (field_odd),
        .pix_in     (pix_in),
        .noise_thr  (noise_thr),
        .strength   (strength),
        .out_valid  (out_valid),
        .pix_out    (pix_out)
    );

    always @(negedge clk) begin
        if (out_valid && tot < MAXGOT) begin
            got_all[tot] = pix_out;
            tot = tot + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pix_valid = 1'b0; line_start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_line(input logic [7:0] thr, input logic [3:0] str, input logic odd);
        noise_thr = thr; strength = str; field_odd = odd;
        line_start = 1'b1; pix_valid = 1'b0;
        @(negedge clk);
        line_start = 1'b0;
        for (int i = 0; i < L; i++) begin
            pix_in = cur[i]; pix_valid = 1'b1;
            @(negedge clk);
        end
        pix_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic int clampi(input int p);
        return (p < 0) ? 0 : ((p > L-1) ? L-1 : p);
    endfunction

    // reference model: filters c_prev against fm, updates fm
    task automatic model_line(input int thr, input int str, input int ph, input bit odd);
        logic [7:0] fo [L];
        int s, te, sc, r, sum, cnt, t, d;
        int offs [5];
        int tp [7];
        offs = '{-9, -4, 0, 4, 9};
        s = (ph == 1) ? 1 : ((ph == 3) ? -1 : 0);
        if (odd) s = -s;
        sc = (str > 10) ? 10 : str;
        te = thr * sc;
        for (int i = 0; i < L; i++) fo[i] = fm[i];
        for (int i = 0; i < L; i++) begin
            r = c_prev[i];
            if (str == 0) begin
                exp_ln[i] = 8'(r);
            end else begin
                tp[0] = c_prev[clampi(i-2)];
                tp[1] = c_prev[clampi(i+2)];
                for (int j = 0; j < 5; j++) tp[2+j] = fo[clampi(i + s + offs[j])];
                sum = r; cnt = 1;
                for (int j = 0; j < 7; j++) begin
                    t = tp[j];
                    d = (t > r) ? t - r : r - t;
                    if (d < te) begin sum += t; cnt++; end
                end
                exp_ln[i] = 8'((sum + cnt/2) / cnt);
            end
            fm[i] = exp_ln[i];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int base, n, thr, str, bs, amp;
        bit odd, prev_odd;

        do_reset();
        // R1: reset state at the ports
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(pix_out == 8'd0, "R1 pix_out after reset", int'(pix_out), 0);

        // R2: first line is silent
        for (int i = 0; i < L; i++) cur[i] = 8'd100;
        base = tot;
        run_line(8'd255, 4'd10, 1'b0);
        chk(tot - base == 0, "R2 first line output count", tot - base, 0);

        // R1/R5: filtered against cleared memory: (5*0+3*100+4)/8 = 38
        base = tot;
        run_line(8'd255, 4'd10, 1'b0);
        chk(tot - base == L, "R2 second line output count", tot - base, L);
        for (int i = 0; i < L; i++)
            chk(got_all[base+i] == 8'd38, "R1/R5 zero memory mean", int'(got_all[base+i]), 38);

        // R8: write-back: (5*38+300+4)/8 = 61
        base = tot;
        run_line(8'd255, 4'd10, 1'b0);
        for (int i = 0; i < L; i++)
            chk(got_all[base+i] == 8'd61, "R8 recursive write-back", int'(got_all[base+i]), 61);

        // R4: narrow threshold excludes the old 61s: output stays 100 (diff 39, thr 20)
        base = tot;
        run_line(8'd20, 4'd1, 1'b0);
        for (int i = 0; i < L; i++)
            chk(got_all[base+i] == 8'd100, "R4 tap exclusion", int'(got_all[base+i]), 100);

        // R11: pixel in line_start cycle is ignored; line keeps L pixels
        do_reset();
        for (int i = 0; i < L; i++) cur[i] = 8'd50;
        run_line(8'd255, 4'd0, 1'b0);
        noise_thr = 8'd255; strength = 4'd0;
        line_start = 1'b1; pix_valid = 1'b1; pix_in = 8'd7;
        @(negedge clk);
        line_start = 1'b0;
        base = tot;
        for (int i = 0; i < L; i++) begin
            pix_in = 8'd50; pix_valid = 1'b1;
            @(negedge clk);
        end
        pix_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(tot - base == L, "R11 ignored pixel count", tot - base, L);
        for (int i = 0; i < L; i++)
            chk(got_all[base+i] == 8'd50, "R11/R9 ignored pixel value", int'(got_all[base+i]), 50);

        // table walk against the model (R3 R4 R5 R6 R7 R8 R9 R10)
        do_reset();
        for (int i = 0; i < L; i++) fm[i] = 8'd0;
        prev_odd = 1'b0;
        for (int k = 0; k < NVEC; k++) begin
            thr = int'(VEC[k][28:21]);
            str = int'(VEC[k][20:17]);
            odd = VEC[k][16];
            bs  = int'(VEC[k][15:8]);
            amp = int'(VEC[k][7:0]);
            for (int i = 0; i < L; i++)
                cur[i] = 8'(bs + ((i*7 + k*13 + (i*i) % 5) % (amp + 1)));
            if (k == 3) cur[0] = 8'd255;
            base = tot;
            run_line(8'(thr), 4'(str), odd);
            n = tot - base;
            if (k == 0) begin
                chk(n == 0, "R2 table first line silent", n, 0);
            end else begin
                model_line(thr, str, (k-1) % 4, prev_odd);
                chk(n == L, "R2 table output count", n, L);
                for (int i = 0; i < L; i++)
                    chk(got_all[base+i] == exp_ln[i],
                        "R3/R4/R5/R6/R7/R8/R9/R10 filtered pixel",
                        int'(got_all[base+i]), int'(exp_ln[i]));
            end
            for (int i = 0; i < L; i++) c_prev[i] = cur[i];
            prev_odd = odd;
        end

        summary();
        $finish;
    end

endmodule